// File: doc/BRIEF.md
# Bi-phase mark serial audio receiver front end

This block takes a bi-phase-mark coded serial audio line and samples it with a much faster local clock. It recovers the half-cell symbols, finds the three code-violating sync patterns that open each subframe, and delivers each decoded subframe with a one-cycle valid pulse. Each subframe comes out as a 28-bit payload plus a 4-bit sync code.

The half-cell timing comes from one of two sources. In automatic lock, the block takes the shortest run between line transitions over a window of transitions as the half-cell length. It then places the sampling strobe at three quarters of that length. In manual lock, the cell length and the strobe offset are programmed values. A busy output follows the stream. It rises on the first sync pattern seen after the receiver is enabled. It falls at a frame boundary once the receiver is disabled, or at once when the line goes quiet. Two sticky flags record a missing sync pattern and the arrival of a block-start pattern. Each flag is cleared by its own one-cycle clear strobe.

Top module: `bmc_rx_front`

## Requirements
- R1: After reset, `busy`, `sub_valid`, `badpre_flag` and `bpre_flag` are 0, and `period_est` is 0.
- R2: `period_est` reports twice the shortest transition-to-transition run, in clocks, seen over the last completed window of 32 line transitions. It is measured in both lock modes, so with half-cells of H clocks it reads 2H.
- R3: With `lock_manual` = 0 and half-cells of 3 to 8 clocks, every subframe is recovered without error. The strobe sits floor(3H/4) clocks after the latest half-cell boundary.
- R4: With `lock_manual` = 1, the half-cell length is `man_period` shifted right by one. The strobe sits `man_strobe` clocks after the latest half-cell boundary. Subframes are recovered for every strobe from 1 to half-cell minus 1.
- R5: Sync patterns are listed oldest half-cell first, with the first half-cell high. The block-start pattern is 11101000, the second-channel pattern is 11100100 and the first-channel pattern is 11100010. Their inversions are accepted as well. `sub_code` bit 0 marks block-start, bit 1 first-channel, bit 2 second-channel, and bit 3 is the line level during the first half-cell.
- R6: `sub_payload[i]` holds time slot 4+i. A slot is 1 when the line changes in the middle of the cell. Bits [3:0] are auxiliary, [23:4] are audio, and 24, 25, 26 and 27 are the validity, user, channel-status and parity bits.
- R7: `busy` rises only when a sync pattern is recognised while `rx_en` is 1. While `busy` is 0, no subframe is delivered, and that includes everything received while disabled.
- R8: With `rx_en` at 0, `busy` falls when a subframe opened by the second-channel pattern completes. That subframe is still delivered, and later subframes are not.
- R9: `busy` falls when no line transition is seen for more than 8 half-cells (4 cells). A gap shorter than that leaves `busy` at 1.
- R10: `badpre_flag` is set when, while `rx_en` is 1, the 8 half-cells that follow a completed subframe are not a sync pattern. It stays set through later good subframes until a one-cycle pulse on `clr_badpre` clears it.
- R11: `bpre_flag` is set when a block-start pattern is recognised while `rx_en` is 1. The other two patterns never set it, and only a pulse on `clr_bpre` clears it.
- R12: `sub_valid` is high for exactly one cycle per delivered subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Bi-phase-mark serial input, synchronised inside the block |
| rx_en | input | 1 | Receive enable |
| lock_manual | input | 1 | 0 selects automatic lock, 1 selects the programmed timing |
| man_period | input | 6 | Programmed cell length in clocks |
| man_strobe | input | 5 | Programmed strobe offset within a half-cell, in clocks |
| clr_badpre | input | 1 | Clear pulse for `badpre_flag` |
| clr_bpre | input | 1 | Clear pulse for `bpre_flag` |
| period_est | output | 8 | Measured cell length in clocks |
| busy | output | 1 | Stream active |
| sub_valid | output | 1 | One-cycle pulse, subframe delivered |
| sub_code | output | 4 | Sync pattern code of the delivered subframe |
| sub_payload | output | 28 | Time slots 4 to 31 of the delivered subframe |
| badpre_flag | output | 1 | Sticky: sync pattern missing |
| bpre_flag | output | 1 | Sticky: block-start pattern seen |

## Verification
The assertions assume the following about the inputs:
- The clear inputs are single-cycle strobes.
- In manual lock, the programmed strobe is nonzero and smaller than the programmed half-cell.
- Line transitions fall on whole-clock half-cell boundaries of at least three clocks.

The stimulus keeps to these assumptions. It drives exact half-cells of fixed length with every strobe limited to the range 1 to half-cell minus 1, and it issues clears through a one-shot pulse generator. It also keeps rx_en changes inside the body of a subframe, never on a sync pattern.

// File: rtl/bmc_rx_front.sv
module bmc_rx_front #(
  parameter int PER_W      = 6,
  parameter int STB_W      = 5,
  parameter int EST_W      = 8,
  parameter int WIN        = 32,
  parameter int IDLE_CELLS = 4,
  parameter int RUN_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rx_en,
  input  logic              lock_manual,
  input  logic [PER_W-1:0]  man_period,
  input  logic [STB_W-1:0]  man_strobe,
  input  logic              clr_badpre,
  input  logic              clr_bpre,
  output logic [EST_W-1:0]  period_est,
  output logic              busy,
  output logic              sub_valid,
  output logic [3:0]        sub_code,
  output logic [27:0]       sub_payload,
  output logic              badpre_flag,
  output logic              bpre_flag
);
  localparam int HC_W = EST_W - 1;
  localparam int WC_W = $clog2(WIN);
  localparam logic [HC_W-1:0] HC_MAX = '1;
  localparam logic [7:0] PAT_B = 8'b1110_1000;
  localparam logic [7:0] PAT_M = 8'b1110_0010;
  localparam logic [7:0] PAT_W = 8'b1110_0100;

  typedef enum logic [1:0] {SEEK, BITS, GAP} st_t;

  logic [2:0]       sq;
  logic [RUN_W-1:0] since;
  logic [HC_W-1:0]  run_min, meas_hc, ph;
  logic [WC_W-1:0]  ecnt;
  logic [6:0]       hist;
  logic [26:0]      pl;
  logic [3:0]       code_q;
  logic [5:0]       hcnt;
  st_t              st;

  wire lvl = sq[1];
  wire tog = sq[1] ^ sq[2];

  // run length since the latest transition, and its clamp to the half-cell range
  wire [HC_W-1:0] run_c   = (since > RUN_W'(HC_MAX)) ? HC_MAX : since[HC_W-1:0];
  wire [HC_W-1:0] new_min = (run_c < run_min) ? run_c : run_min;

  wire [HC_W+1:0] stb3 = {2'b00, meas_hc} + {1'b0, meas_hc, 1'b0};
  wire [HC_W-1:0] hc   = lock_manual ? HC_W'(man_period >> 1) : meas_hc;
  wire [HC_W-1:0] stb  = lock_manual ? HC_W'(man_strobe) : stb3[HC_W+1:2];
  wire            ready = hc >= HC_W'(2);
  wire [RUN_W-1:0] lim  = RUN_W'(hc) * RUN_W'(2 * IDLE_CELLS);
  wire            idle  = ready && (since > lim);

  wire [HC_W-1:0] ph_eff = tog ? '0 : ph;
  wire            samp   = ready && !idle && (ph_eff == stb);

  wire [7:0] win  = {hist, lvl};
  wire [7:0] norm = win[7] ? win : ~win;
  wire       is_b = norm == PAT_B;
  wire       is_m = norm == PAT_M;
  wire       is_w = norm == PAT_W;
  wire       hit  = is_b | is_m | is_w;
  wire [3:0] code_now = {win[7], is_w, is_m, is_b};

  wire gap_end  = (st == GAP) && (hcnt == 6'd7);
  wire look     = samp && ((st == SEEK) || gap_end);
  wire hit_now  = look && hit;
  wire miss_now = samp && gap_end && !hit;
  wire done_now = samp && (st == BITS) && (hcnt == 6'd55);
  wire bit_now  = hist[0] ^ lvl;

  assign period_est = {meas_hc, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sq <= '0; since <= '1;
    end else begin
      sq <= {sq[1:0], rx_line};
      if (tog) since <= RUN_W'(1);
      else if (~&since) since <= since + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_min <= '1; ecnt <= '0; meas_hc <= '0;
    end else if (tog) begin
      if (ecnt == WC_W'(WIN - 1)) begin
        meas_hc <= new_min; run_min <= '1; ecnt <= '0;
      end else begin
        run_min <= new_min; ecnt <= ecnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ph <= '0;
    else if (tog) ph <= HC_W'(1);
    else if (!ready || ph == hc - 1'b1) ph <= '0;
    else ph <= ph + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= SEEK; hcnt <= '0; hist <= '0; pl <= '0; code_q <= '0;
    end else if (idle) begin
      st <= SEEK; hcnt <= '0;
    end else if (samp) begin
      hist <= win[6:0];
      if (hit_now) begin
        st <= BITS; hcnt <= '0; code_q <= code_now;
      end else if (miss_now) begin
        st <= SEEK; hcnt <= '0;
      end else if (st == BITS) begin
        if (hcnt[0] && hcnt != 6'd55) pl[hcnt[5:1]] <= bit_now;
        if (done_now) begin st <= GAP; hcnt <= '0; end
        else hcnt <= hcnt + 1'b1;
      end else if (st == GAP) begin
        hcnt <= hcnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; sub_valid <= 1'b0; sub_code <= '0; sub_payload <= '0;
      badpre_flag <= 1'b0; bpre_flag <= 1'b0;
    end else begin
      sub_valid <= done_now && busy;
      if (done_now) begin
        sub_payload <= {bit_now, pl};
        sub_code    <= code_q;
      end
      if (idle) busy <= 1'b0;
      else if (hit_now && rx_en) busy <= 1'b1;
      else if (done_now && !rx_en && code_q[2]) busy <= 1'b0;
      if (miss_now && rx_en) badpre_flag <= 1'b1;
      else if (clr_badpre) badpre_flag <= 1'b0;
      if (hit_now && is_b && rx_en) bpre_flag <= 1'b1;
      else if (clr_bpre) bpre_flag <= 1'b0;
    end

  assert_code_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> $countones(sub_code[2:0]) == 1);
  assert_valid_needs_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> $past(busy));
  assert_busy_rise_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rx_en));
  assert_busy_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(rx_en)) |-> $past(idle));
  assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !busy);
  assert_badpre_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(badpre_flag) |-> $past(clr_badpre));
  assert_bpre_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bpre_flag) |-> (code_q[0] && $past(rx_en)));
  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |=> !sub_valid);
endmodule

// File: tb/test_bmc_rx_front.sv
`timescale 1ns/1ps
module test_bmc_rx_front;
  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, lock_manual = 1'b0;
  logic line_lvl = 1'b0, clr_badpre = 1'b0, clr_bpre = 1'b0;
  logic [5:0] man_period = '0;
  logic [4:0] man_strobe = '0;
  logic [7:0] period_est;
  logic busy, sub_valid, badpre_flag, bpre_flag;
  logic [3:0] sub_code;
  logic [27:0] sub_payload;

  always #4 clk = ~clk;

  bmc_rx_front i_bmc_rx_front (
    .clk(clk), .rst_n(rst_n), .rx_line(line_lvl), .rx_en(rx_en),
    .lock_manual(lock_manual), .man_period(man_period), .man_strobe(man_strobe),
    .clr_badpre(clr_badpre), .clr_bpre(clr_bpre), .period_est(period_est),
    .busy(busy), .sub_valid(sub_valid), .sub_code(sub_code),
    .sub_payload(sub_payload), .badpre_flag(badpre_flag), .bpre_flag(bpre_flag));

  int n_chk = 0, n_bad = 0, H = 4;
  int got_n = 0, exp_n = 0, cmp_base = 0;
  int clrb_req = 0, clrb_ack = 0, clrp_req = 0, clrp_ack = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [27:0] got_w [256];
  logic [3:0]  got_c [256];
  logic [27:0] exp_w [256];
  logic [3:0]  exp_c [256];

  always @(negedge clk) begin
    if (sub_valid) begin
      got_w[got_n % 256] = sub_payload;
      got_c[got_n % 256] = sub_code;
      got_n = got_n + 1;
    end
    clr_bpre   <= (clrb_req != clrb_ack);
    clrb_ack   <= clrb_req;
    clr_badpre <= (clrp_req != clrp_ack);
    clrp_ack   <= clrp_req;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [27:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[27:0];
  endfunction

  task automatic half(input logic v);
    line_lvl = v;
    repeat (H) @(negedge clk);
  endtask

  task automatic checkpoint(input int ck);
    case (ck)
      1: begin
        check(period_est == 8'(2 * H), "R2", "period after warm-up", period_est, 2 * H);
        check(got_n == exp_n, "R7", "nothing delivered while disabled", got_n, exp_n);
        check(busy == 1'b1, "R7", "busy after enabled sync", busy, 1);
      end
      2: begin
        check(bpre_flag == 1'b1, "R11", "block-start flag set", bpre_flag, 1);
        clrb_req++;
      end
      3: begin
        check(bpre_flag == 1'b0, "R11", "block-start flag cleared", bpre_flag, 0);
        check(badpre_flag == 1'b0, "R10", "no missing sync yet", badpre_flag, 0);
      end
      4: begin
        check(badpre_flag == 1'b1, "R10", "missing sync flagged", badpre_flag, 1);
        check(bpre_flag == 1'b0, "R11", "first-channel sync leaves flag", bpre_flag, 0);
      end
      5: begin
        check(badpre_flag == 1'b1, "R10", "flag sticky over good subframes", badpre_flag, 1);
        clrp_req++;
      end
      6: begin
        check(badpre_flag == 1'b0, "R10", "missing-sync flag cleared", badpre_flag, 0);
        check(bpre_flag == 1'b1, "R11", "block-start flag set again", bpre_flag, 1);
      end
      7: rx_en = 1'b0;
      8: check(busy == 1'b0, "R8", "busy after frame end while disabled", busy, 0);
      9: begin
        check(got_n == exp_n, "R8", "no delivery after frame end", got_n, exp_n);
        rx_en = 1'b1;
      end
      10: check(busy == 1'b1, "R7", "busy after re-enable", busy, 1);
      11: begin
        check(got_n == exp_n, "R7", "warm-up not delivered", got_n, exp_n);
        check(busy == 1'b1, "R7", "busy on first sync", busy, 1);
      end
      default: ;
    endcase
  endtask

  task automatic send_sub(input int kind, input logic [27:0] pl, input int ck, input bit dlv);
    logic [7:0] pat;
    logic pol;
    pat = (kind == 0) ? 8'hE8 : (kind == 1) ? 8'hE2 : 8'hE4;
    pol = ~line_lvl;
    for (int i = 7; i >= 0; i--) half(pol ? pat[i] : ~pat[i]);
    for (int b = 0; b < 28; b++) begin
      half(~line_lvl);
      half(pl[b] ? ~line_lvl : line_lvl);
      if (b == 1) checkpoint(ck);
    end
    if (dlv) begin
      exp_w[exp_n % 256] = pl;
      exp_c[exp_n % 256] = {pol, kind == 2, kind == 1, kind == 0};
      exp_n++;
    end
  endtask

  task automatic send_zero_bits(input int n);
    for (int b = 0; b < n; b++) begin
      half(~line_lvl);
      half(line_lvl);
    end
  endtask

  task automatic compare(input string req);
    check(got_n == exp_n, "R12", "delivered subframe count", got_n, exp_n);
    for (int k = cmp_base; k < exp_n; k++) begin
      if (k < got_n) begin
        check(got_w[k % 256] == exp_w[k % 256], req, "payload (R6 slot order)",
              got_w[k % 256], exp_w[k % 256]);
        check(got_c[k % 256] == exp_c[k % 256], "R5", "sync code",
              got_c[k % 256], exp_c[k % 256]);
      end
    end
    exp_n = got_n;
    cmp_base = got_n;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cfg(input bit man, input int per, input int stb, input int h);
    H = h;
    lock_manual = man;
    man_period = 6'(per);
    man_strobe = 5'(stb);
    rx_en = 1'b0;
    do_reset();
    send_sub(0, '1, 0, 1'b0);
    send_sub(2, '1, 0, 1'b0);
    rx_en = 1'b1;
    send_sub(0, rnd(), 11, 1'b1);
    send_sub(2, rnd(), 0, 1'b1);
    send_sub(1, rnd(), 0, 1'b1);
    send_sub(2, rnd(), 0, 1'b1);
    send_sub(1, rnd(), 0, 1'b1);
    send_sub(2, rnd(), 0, 1'b1);
    repeat (12 * h) @(negedge clk);
    check(period_est == 8'(2 * h), "R2", "period estimate", period_est, 2 * h);
    compare(man ? "R4" : "R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(sub_valid == 1'b0, "R1", "valid in reset", sub_valid, 0);
    check(badpre_flag == 1'b0 && bpre_flag == 1'b0, "R1", "flags in reset",
          {badpre_flag, bpre_flag}, 0);
    check(period_est == 8'd0, "R1", "period in reset", period_est, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed sequence, automatic lock, 4-clock half-cells
    H = 4;
    send_sub(0, '1, 0, 1'b0);
    send_sub(2, '1, 0, 1'b0);
    send_sub(1, '1, 0, 1'b0);
    send_sub(2, '1, 0, 1'b0);
    rx_en = 1'b1;
    send_sub(0, rnd(), 1, 1'b1);
    send_sub(2, rnd(), 2, 1'b1);
    send_sub(1, 28'h0000000, 3, 1'b1);
    send_sub(2, 28'hFFFFFFF, 0, 1'b1);
    send_zero_bits(4);
    send_sub(1, 28'hA5A5A5A, 4, 1'b1);
    send_sub(2, rnd(), 5, 1'b1);
    send_sub(0, rnd(), 6, 1'b1);
    send_sub(2, rnd(), 0, 1'b1);
    send_sub(1, rnd(), 7, 1'b1);
    send_sub(2, rnd(), 0, 1'b1);
    send_sub(0, rnd(), 8, 1'b0);
    send_sub(2, rnd(), 0, 1'b0);
    send_sub(1, rnd(), 9, 1'b0);
    send_sub(2, rnd(), 10, 1'b1);
    repeat (4 * H) @(negedge clk);
    check(busy == 1'b1, "R9", "busy over short gap", busy, 1);
    repeat (6 * H) @(negedge clk);
    check(busy == 1'b0, "R9", "busy after long gap", busy, 0);
    compare("R6");

    // sweeps over both lock modes
    for (int h = 3; h <= 8; h++) if (h != 7) run_cfg(1'b0, 0, 0, h);
    for (int s = 1; s <= 4; s++) run_cfg(1'b1, 10, s, 5);
    run_cfg(1'b1, 11, 2, 5);
    for (int s = 1; s <= 6; s++) run_cfg(1'b1, 14, s, 7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule